// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a host processor bus and a data converter core. It decodes active-low chip select, read and write strobes together with a byte-address line and a bus-width select. A write issued while the chip is selected sends a start pulse to the core. A status flag shows whether a conversion is in progress. When the core reports completion, the block captures the 12-bit result and an overrange bit in an output latch.

On a read, the latched result is presented on a data-out bus that has one output-enable per byte lane. The enables stand in for tri-state buffers. With the bus-width select low, the host reads the result as two bytes through lane 0, and the byte-address line chooses which byte. With the bus-width select high, the whole result appears in one 16-bit read. The overrange bit always travels in the high byte. It sits just above the result's top bit.

Top module: `conv_host_if`

## Requirements
- R1: A low level on `wr_n` while `cs_n` is low produces exactly one single-cycle `conv_start` pulse per strobe, however long the strobe lasts. The pulse is high after the second rising edge at which the strobe is first sampled low.
- R2: With `cs_n` high, the write strobe starts nothing, `eoc` is unchanged, and no lane is enabled.
- R3: With `rd_n` high, `doe` is 0 and `dout` is 0.
- R4: With `cs_n`, `rd_n` and `wide_bus` low and `byte_sel` = 0, `doe` = 2'b01 and `dout[7:0]` = result bits 7..0. All other `dout` bits are 0.
- R5: With `cs_n`, `rd_n` and `wide_bus` low and `byte_sel` = 1, `doe` = 2'b01 and `dout[7:0]` = {3'b000, overrange, result bits 11..8}. All other `dout` bits are 0.
- R6: With `cs_n` and `rd_n` low and `wide_bus` high, `doe` = 2'b11 and `dout` = {3'b000, overrange, result[11:0]}, whatever `byte_sel` is.
- R7: `eoc` goes low on the same edge that raises `conv_start` and stays low until completion.
- R8: The output latch changes only when `conv_done` is sampled high, so a read during a conversion returns the previous result.
- R9: A `conv_done` pulse sampled high captures `conv_code` and `conv_ovr` and sets `eoc` on that same edge. If a new start is issued on that edge, the start takes priority and `eoc` stays low.
- R10: After reset, `eoc` is 1, `conv_start` is 0 and the latched result and overrange bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; starts a conversion |
| byte_sel | input | 1 | Byte address in narrow mode: 0 = low byte, 1 = high byte |
| wide_bus | input | 1 | 1 = both bytes in one read, 0 = one byte per read |
| conv_start | output | 1 | Single-cycle start pulse to the core |
| conv_done | input | 1 | Single-cycle completion pulse from the core |
| conv_code | input | 12 | Result from the core, valid with `conv_done` |
| conv_ovr | input | 1 | Overrange from the core, valid with `conv_done` |
| eoc | output | 1 | 1 = idle or complete, 0 = conversion in progress |
| dout | output | 16 | Read data |
| doe | output | 2 | Per-lane output enable, bit n for `dout` byte n |

## Verification
The bench holds the write strobe low for several cycles and counts start pulses. A design that is level-sensitive instead of edge-detecting would issue a burst of starts here. It reads back the result during a conversion, which catches a latch that follows the core's live code instead of waiting for completion. A table walks every combination of select, read, byte address and width. This exposes swapped byte lanes, an overrange bit that is missing or misplaced in the high byte, and lanes that stay enabled when chip select or read is inactive. A write with chip select high must leave `eoc` and the start line untouched; a design that ignored chip select would drop `eoc` here.

// File: rtl/conv_if_pkg.sv
package conv_if_pkg;
  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int BUS_W  = LANES * BYTE_W;

  typedef enum logic {
    BUS_NARROW = 1'b0,
    BUS_WIDE   = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/conv_if_strobe.sv
module conv_if_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic start_set,
  output logic start
);
  logic req;
  logic req_q, req_qq, start_q;
  logic req_d, req_qd, start_d;

  assign req = ~cs_n & ~wr_n;

  always_comb begin
    req_d   = req;
    req_qd  = req_q;
    start_d = req_q & ~req_qq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      req_qq  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      req_qq  <= req_qd;
      start_q <= start_d;
    end
  end

  assign start_set = start_d;
  assign start     = start_q;
endmodule

// File: rtl/conv_if_result.sv
module conv_if_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_set,
  input  logic             done,
  input  logic [RES_W-1:0] code_in,
  input  logic             ovr_in,
  output logic             eoc,
  output logic [RES_W-1:0] code_q,
  output logic             ovr_q
);
  logic             eoc_r, eoc_d;
  logic [RES_W-1:0] code_r, code_d;
  logic             ovr_r, ovr_d;
  logic             latch_en;

  assign latch_en = done;

  always_comb begin
    eoc_d  = eoc_r;
    code_d = code_r;
    ovr_d  = ovr_r;
    if (latch_en) begin
      code_d = code_in;
      ovr_d  = ovr_in;
      eoc_d  = 1'b1;
    end
    if (start_set) begin
      eoc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_r  <= 1'b1;
      code_r <= '0;
      ovr_r  <= 1'b0;
    end else begin
      eoc_r <= eoc_d;
      if (latch_en) begin
        code_r <= code_d;
        ovr_r  <= ovr_d;
      end
    end
  end

  assign eoc    = eoc_r;
  assign code_q = code_r;
  assign ovr_q  = ovr_r;
endmodule

// File: rtl/conv_if_busdrv.sv
module conv_if_busdrv #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int BUS_W = LANES * BYTE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int PAD_W = BUS_W - RES_W - 1
) (
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [SEL_W-1:0] byte_sel,
  input  logic             wide_bus,
  input  logic [RES_W-1:0] code_q,
  input  logic             ovr_q,
  output logic [BUS_W-1:0] dout,
  output logic [LANES-1:0] doe
);
  logic [BUS_W-1:0]  word;
  logic [BYTE_W-1:0] lane_data [LANES];
  logic              rd_en;

  assign word  = {{PAD_W{1'b0}}, ovr_q, code_q};
  assign rd_en = ~cs_n & ~rd_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_data[l] = word[l*BYTE_W +: BYTE_W];
  end

  always_comb begin
    doe  = '0;
    dout = '0;
    if (rd_en) begin
      if (wide_bus == conv_if_pkg::BUS_WIDE) begin
        doe  = '1;
        dout = word;
      end else begin
        doe[0] = 1'b1;
        for (int l = 0; l < LANES; l++) begin
          if (byte_sel == SEL_W'(l)) dout[BYTE_W-1:0] = lane_data[l];
        end
      end
    end
  end
endmodule

// File: rtl/conv_host_if.sv
module conv_host_if #(
  parameter int RES_W  = conv_if_pkg::RES_W,
  parameter int BYTE_W = conv_if_pkg::BYTE_W,
  parameter int LANES  = conv_if_pkg::LANES,
  localparam int BUS_W = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             byte_sel,
  input  logic             wide_bus,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_code,
  input  logic             conv_ovr,
  output logic             eoc,
  output logic [BUS_W-1:0] dout,
  output logic [LANES-1:0] doe
);
  logic             start_set;
  logic [RES_W-1:0] code_q;
  logic             ovr_q;

  conv_if_strobe u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .start_set (start_set),
    .start     (conv_start)
  );

  conv_if_result #(.RES_W(RES_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_set (start_set),
    .done      (conv_done),
    .code_in   (conv_code),
    .ovr_in    (conv_ovr),
    .eoc       (eoc),
    .code_q    (code_q),
    .ovr_q     (ovr_q)
  );

  conv_if_busdrv #(.RES_W(RES_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_bus (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .byte_sel (byte_sel),
    .wide_bus (wide_bus),
    .code_q   (code_q),
    .ovr_q    (ovr_q),
    .dout     (dout),
    .doe      (doe)
  );
endmodule

// File: rtl/conv_if_chk.sv
module conv_if_chk #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int BUS_W = LANES * BYTE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             byte_sel,
  input logic             wide_bus,
  input logic             conv_start,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_code,
  input logic             conv_ovr,
  input logic             eoc,
  input logic [BUS_W-1:0] dout,
  input logic [LANES-1:0] doe
);
  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R1
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(!cs_n && !wr_n, 2));

  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (doe == '0 && dout == '0));

  // R7
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !eoc);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (eoc || conv_start));

  // R4
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_bus |-> ($countones(doe) <= 1));
endmodule

bind conv_host_if conv_if_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_chk (.*);

// File: tb/conv_host_if_test.sv
module conv_host_if_test;
  logic        clk;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n, byte_sel, wide_bus;
  logic        conv_start, conv_done, conv_ovr, eoc;
  logic [11:0] conv_code;
  logic [15:0] dout;
  logic [1:0]  doe;

  int errors = 0;
  int checks = 0;
  int nstarts = 0;
  bit finished = 0;

  conv_host_if uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .byte_sel(byte_sel), .wide_bus(wide_bus), .conv_start(conv_start),
    .conv_done(conv_done), .conv_code(conv_code), .conv_ovr(conv_ovr),
    .eoc(eoc), .dout(dout), .doe(doe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && conv_start) nstarts++;

  // {cs_n, rd_n, byte_sel, wide_bus, doe[1:0], dout[15:0]} with latch = A5C, ovr = 1
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {4'b1000, 2'b00, 16'h0000},  // R2 deselected read
    {4'b1001, 2'b00, 16'h0000},  // R2
    {4'b0100, 2'b00, 16'h0000},  // R3 no read strobe
    {4'b0111, 2'b00, 16'h0000},  // R3
    {4'b0000, 2'b01, 16'h005C},  // R4 low byte
    {4'b0010, 2'b01, 16'h001A},  // R5 high byte with overrange
    {4'b0001, 2'b11, 16'h1A5C},  // R6 wide
    {4'b0011, 2'b11, 16'h1A5C}   // R6 byte_sel ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; byte_sel = 1'b0; wide_bus = 1'b0;
  endtask

  task automatic start_conv(input int hold);
    int n0;
    n0 = nstarts;
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    check("R1 no start after one edge", conv_start, 0);
    @(negedge clk);
    check("R1 start pulse", conv_start, 1);
    check("R7 eoc low at start", eoc, 0);
    for (int i = 0; i < hold; i++) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 one start per strobe", nstarts - n0, 1);
    check("R7 eoc stays low", eoc, 0);
  endtask

  task automatic finish_conv(input logic [11:0] code, input logic ovr);
    conv_code = code; conv_ovr = ovr; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; conv_code = 12'h000; conv_ovr = 1'b0;
    check("R9 eoc set by done", eoc, 1);
  endtask

  initial begin
    idle_bus();
    conv_done = 1'b0; conv_code = '0; conv_ovr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 eoc", eoc, 1);
    check("R10 start", conv_start, 0);
    check("R10 doe idle", doe, 0);
    cs_n = 1'b0; rd_n = 1'b0; wide_bus = 1'b1;
    #1 check("R10 latch zero", dout, 16'h0000);
    check("R10 doe wide", doe, 2'b11);
    @(negedge clk);
    idle_bus();

    // first conversion with long write strobe, overrange set
    start_conv(6);
    finish_conv(12'hA5C, 1'b1);

    // table of decodes
    for (int v = 0; v < NV; v++) begin
      {cs_n, rd_n, byte_sel, wide_bus} = VEC[v][21:18];
      #1;
      check($sformatf("R2-6 vec%0d doe", v), doe, VEC[v][17:16]);
      check($sformatf("R2-6 vec%0d dout", v), dout, VEC[v][15:0]);
      @(negedge clk);
    end
    idle_bus();

    // R2 write while deselected
    wr_n = 1'b0; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    check("R2 no start when deselected", nstarts, 1);
    check("R2 eoc unchanged", eoc, 1);

    // R8 read during a conversion returns previous result
    start_conv(0);
    conv_code = 12'h3C1; conv_ovr = 1'b0;
    cs_n = 1'b0; rd_n = 1'b0; wide_bus = 1'b1;
    #1 check("R8 old result during busy", dout, 16'h1A5C);
    @(negedge clk);
    check("R8 old result held", dout, 16'h1A5C);
    idle_bus();
    finish_conv(12'h3C1, 1'b0);
    cs_n = 1'b0; rd_n = 1'b0; byte_sel = 1'b1;
    #1 check("R5 high byte no overrange", dout, 16'h0003);
    byte_sel = 1'b0;
    #1 check("R4 low byte", dout, 16'h00C1);
    @(negedge clk);
    idle_bus();

    // R9 done coinciding with a new start: start wins
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    conv_code = 12'h7FF; conv_ovr = 1'b0; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check("R9 start priority over done", eoc, 0);
    check("R9 start pulse with done", conv_start, 1);
    idle_bus();
    cs_n = 1'b0; rd_n = 1'b0; wide_bus = 1'b1;
    #1 check("R9 result captured with start", dout, 16'h07FF);
    @(negedge clk);
    idle_bus();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule